// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside a NOR-style flash array and watches the bus write cycles aimed at it. Each write is presented for one clock as an address, a data word and a strobe. The decoder follows the unlock prefix and the multi-write command sequences. When a sequence completes and the command is permitted, it raises exactly one request pulse for one clock. It also keeps the selector that tells the read path whether reads return array data, identifier codes or the status register.

The write state machine reports whether a program is running, an erase is running, or an erase is held suspended. The decoder uses that report to narrow the set of commands it accepts. A rejected command, and any write that breaks a sequence, sends the tracker back to its idle step with no request.

State machine steps: `ST_IDLE` (waiting for the first unlock), `ST_UNLK1` (first unlock seen), `ST_UNLK2` (second unlock seen, command byte expected), `ST_ESETUP` (erase set-up seen), `ST_EUNLK1` and `ST_EUNLK2` (the repeated unlock pair of an erase). Transitions: a matching write advances one step. The command write in `ST_UNLK2` or `ST_EUNLK2` returns to `ST_IDLE` and may issue a request. The set-up code moves `ST_UNLK2` to `ST_ESETUP`. Any non-matching write returns to `ST_IDLE`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: During and after reset, `req` is all zero and `read_sel` is 0 (array), so array reads need no command.
- R2: A command is the write sequence AAh at address 5555h, then 55h at 2AAAh, then a command byte at 5555h. Only address bits 14:0 and data bits 7:0 are compared. Command bytes: F0h read array (req bit 0), 90h read ID (bit 1), 70h read status (bit 2), 50h clear status (bit 3), A0h page program (bit 4), B0h suspend (bit 7), D0h resume (bit 8), C0h sleep (bit 9), E0h abort (bit 10). The request pulses for one clock, in the cycle after the clock edge that samples the final write.
- R3: Erase is 80h at 5555h, then AAh at 5555h, then 55h at 2AAAh, then a sixth write. 10h at 5555h requests chip erase (bit 5). 30h at any address requests sector erase (bit 6), and `req_sector` takes address bits 19:16 of that write.
- R4: A write that does not match the next expected address and byte returns the tracker to idle without a request. A new command then needs the full prefix.
- R5: With no operation running and no suspend, read array, read ID, read status, clear status, program, both erases and sleep are accepted. Suspend, resume and abort are ignored.
- R6: While `busy_prog` is high, only read status, sleep and abort are accepted. `busy_prog` takes precedence over the other two status inputs.
- R7: While `busy_erase` is high with no suspend, only read status, suspend, sleep and abort are accepted.
- R8: While `suspended` is high (and `busy_prog` low), only read array, read status, abort and resume are accepted. Sleep is ignored.
- R9: `read_sel` becomes 0 (array) after read array, 1 (ID) after read ID, and 2 (status) after read status, program, either erase, suspend, sleep or abort. It is left unchanged by clear status, resume and any rejected or broken sequence.
- R10: At most one `req` bit is high in any cycle, and no request follows a cycle without a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 20 | Write address |
| wr_data | input | 16 | Write data; only the low byte is decoded |
| busy_prog | input | 1 | Write state machine is running a page program |
| busy_erase | input | 1 | Write state machine is running or holding an erase |
| suspended | input | 1 | Erase is suspended |
| req | output | 11 | One-hot request pulse, bit order as in R2/R3 |
| req_sector | output | 4 | Sector of the last accepted sector erase |
| read_sel | output | 2 | Read path source: 0 array, 1 ID, 2 status |

## Verification
The hardest situation to reach from the ports is a completed six-write erase sequence, or a correct command, that arrives while the status inputs put the decoder in a narrowed context. In the stimulus, the context is chosen at random before each sequence, so every command meets every context. Sequences are built whole and then, now and then, one write has its byte or address damaged. This exercises aborts at every step, including the second unlock pair of an erase. Upper address and data bits are randomised throughout to show that they are ignored.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int NUM_REQ = 11;

    typedef enum logic [3:0] {
        CMD_NONE         = 4'd0,
        CMD_RD_ARRAY     = 4'd1,
        CMD_RD_ID        = 4'd2,
        CMD_RD_STATUS    = 4'd3,
        CMD_CLR_STATUS   = 4'd4,
        CMD_PROGRAM      = 4'd5,
        CMD_CHIP_ERASE   = 4'd6,
        CMD_SECTOR_ERASE = 4'd7,
        CMD_SUSPEND      = 4'd8,
        CMD_RESUME       = 4'd9,
        CMD_SLEEP        = 4'd10,
        CMD_ABORT        = 4'd11
    } cmd_e;

    typedef enum logic [1:0] {
        SEL_ARRAY  = 2'd0,
        SEL_ID     = 2'd1,
        SEL_STATUS = 2'd2
    } rsel_e;

    typedef enum logic [1:0] {
        CTX_IDLE  = 2'd0,
        CTX_PROG  = 2'd1,
        CTX_ERASE = 2'd2,
        CTX_SUSP  = 2'd3
    } ctx_e;

    localparam logic [7:0] BYTE_UNLK1   = 8'hAA;
    localparam logic [7:0] BYTE_UNLK2   = 8'h55;
    localparam logic [7:0] BYTE_ESETUP  = 8'h80;
    localparam logic [7:0] BYTE_CHIP    = 8'h10;
    localparam logic [7:0] BYTE_SECTOR  = 8'h30;

    // request bit positions, one below the command encoding
    localparam int REQ_RD_ARRAY  = 0;
    localparam int REQ_RD_ID     = 1;
    localparam int REQ_RD_STATUS = 2;
    localparam int REQ_CLR       = 3;
    localparam int REQ_PROGRAM   = 4;
    localparam int REQ_CHIP      = 5;
    localparam int REQ_SECTOR    = 6;
    localparam int REQ_SUSPEND   = 7;
    localparam int REQ_RESUME    = 8;
    localparam int REQ_SLEEP     = 9;
    localparam int REQ_ABORT     = 10;

    function automatic cmd_e decode_byte(input logic [7:0] b);
        cmd_e c;
        unique case (b)
            8'hF0:   c = CMD_RD_ARRAY;
            8'h90:   c = CMD_RD_ID;
            8'h70:   c = CMD_RD_STATUS;
            8'h50:   c = CMD_CLR_STATUS;
            8'hA0:   c = CMD_PROGRAM;
            8'hB0:   c = CMD_SUSPEND;
            8'hD0:   c = CMD_RESUME;
            8'hC0:   c = CMD_SLEEP;
            8'hE0:   c = CMD_ABORT;
            default: c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/flash_seq_tracker.sv
module flash_seq_tracker
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int CMP_W  = 15,
    parameter logic [CMP_W-1:0] UNLK_ADDR_A = 15'h5555,
    parameter logic [CMP_W-1:0] UNLK_ADDR_B = 15'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cmd_e              cmd_kind
);

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_UNLK1  = 3'd1,
        ST_UNLK2  = 3'd2,
        ST_ESETUP = 3'd3,
        ST_EUNLK1 = 3'd4,
        ST_EUNLK2 = 3'd5
    } step_e;

    step_e      step_q;
    step_e      step_n;
    logic       at_a;
    logic       at_b;
    logic [7:0] low_byte;

    assign at_a     = (wr_addr[CMP_W-1:0] == UNLK_ADDR_A);
    assign at_b     = (wr_addr[CMP_W-1:0] == UNLK_ADDR_B);
    assign low_byte = wr_data[7:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
        end else begin
            step_q <= step_n;
        end
    end

    always_comb begin
        step_n   = step_q;
        cmd_kind = CMD_NONE;
        if (wr_en) begin
            step_n = ST_IDLE;
            unique case (step_q)
                ST_IDLE: begin
                    if (at_a && low_byte == BYTE_UNLK1) step_n = ST_UNLK1;
                end
                ST_UNLK1: begin
                    if (at_b && low_byte == BYTE_UNLK2) step_n = ST_UNLK2;
                end
                ST_UNLK2: begin
                    if (at_a) begin
                        if (low_byte == BYTE_ESETUP) step_n = ST_ESETUP;
                        else                         cmd_kind = decode_byte(low_byte);
                    end
                end
                ST_ESETUP: begin
                    if (at_a && low_byte == BYTE_UNLK1) step_n = ST_EUNLK1;
                end
                ST_EUNLK1: begin
                    if (at_b && low_byte == BYTE_UNLK2) step_n = ST_EUNLK2;
                end
                ST_EUNLK2: begin
                    if (low_byte == BYTE_SECTOR)            cmd_kind = CMD_SECTOR_ERASE;
                    else if (at_a && low_byte == BYTE_CHIP) cmd_kind = CMD_CHIP_ERASE;
                end
                default: step_n = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
    import flash_cmd_pkg::*;
(
    input  cmd_e cmd_in,
    input  logic busy_prog,
    input  logic busy_erase,
    input  logic suspended,
    output cmd_e cmd_out
);

    ctx_e ctx;
    logic ok;

    always_comb begin
        if (busy_prog)       ctx = CTX_PROG;
        else if (suspended)  ctx = CTX_SUSP;
        else if (busy_erase) ctx = CTX_ERASE;
        else                 ctx = CTX_IDLE;
    end

    always_comb begin
        ok = 1'b0;
        unique case (ctx)
            CTX_IDLE:  ok = cmd_in inside {CMD_RD_ARRAY, CMD_RD_ID, CMD_RD_STATUS,
                                           CMD_CLR_STATUS, CMD_PROGRAM, CMD_CHIP_ERASE,
                                           CMD_SECTOR_ERASE, CMD_SLEEP};
            CTX_PROG:  ok = cmd_in inside {CMD_RD_STATUS, CMD_SLEEP, CMD_ABORT};
            CTX_ERASE: ok = cmd_in inside {CMD_RD_STATUS, CMD_SUSPEND, CMD_SLEEP, CMD_ABORT};
            CTX_SUSP:  ok = cmd_in inside {CMD_RD_ARRAY, CMD_RD_STATUS, CMD_ABORT, CMD_RESUME};
            default:   ok = 1'b0;
        endcase
        cmd_out = ok ? cmd_in : CMD_NONE;
    end

endmodule

// File: rtl/flash_req_reg.sv
module flash_req_reg
    import flash_cmd_pkg::*;
#(
    parameter int SECT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_e               cmd,
    input  logic [SECT_W-1:0]  sect_in,
    output logic [NUM_REQ-1:0] req,
    output logic [SECT_W-1:0]  req_sector,
    output logic [1:0]         read_sel
);

    logic [NUM_REQ-1:0] req_n;
    rsel_e              sel_q;
    rsel_e              sel_n;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
        assign req_n[i] = (cmd == cmd_e'(i + 1));
    end

    always_comb begin
        sel_n = sel_q;
        unique case (cmd)
            CMD_RD_ARRAY: sel_n = SEL_ARRAY;
            CMD_RD_ID:    sel_n = SEL_ID;
            CMD_RD_STATUS, CMD_PROGRAM, CMD_CHIP_ERASE, CMD_SECTOR_ERASE,
            CMD_SUSPEND, CMD_SLEEP, CMD_ABORT:
                          sel_n = SEL_STATUS;
            default:      sel_n = sel_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req        <= '0;
            sel_q      <= SEL_ARRAY;
            req_sector <= '0;
        end else begin
            req   <= req_n;
            sel_q <= sel_n;
            if (cmd == CMD_SECTOR_ERASE) req_sector <= sect_in;
        end
    end

    assign read_sel = sel_q;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int CMP_W    = 15,
    parameter int SECT_LSB = 16,
    localparam int SECT_W  = ADDR_W - SECT_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               busy_prog,
    input  logic               busy_erase,
    input  logic               suspended,
    output logic [NUM_REQ-1:0] req,
    output logic [SECT_W-1:0]  req_sector,
    output logic [1:0]         read_sel
);

    cmd_e raw_cmd;
    cmd_e ok_cmd;

    flash_seq_tracker #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CMP_W  (CMP_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cmd_kind (raw_cmd)
    );

    flash_cmd_gate u_gate (
        .cmd_in     (raw_cmd),
        .busy_prog  (busy_prog),
        .busy_erase (busy_erase),
        .suspended  (suspended),
        .cmd_out    (ok_cmd)
    );

    flash_req_reg #(
        .SECT_W (SECT_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (ok_cmd),
        .sect_in    (wr_addr[ADDR_W-1:SECT_LSB]),
        .req        (req),
        .req_sector (req_sector),
        .read_sel   (read_sel)
    );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk
    import flash_cmd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               busy_prog,
    input logic               busy_erase,
    input logic               suspended,
    input logic [NUM_REQ-1:0] req,
    input logic [1:0]         read_sel
);

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req)); // R10

    AST_NO_STROBE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (req == '0)); // R10

    AST_PROG_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        busy_prog |=> !(req[REQ_RD_ARRAY] | req[REQ_RD_ID] | req[REQ_CLR] | req[REQ_PROGRAM]
                        | req[REQ_CHIP] | req[REQ_SECTOR] | req[REQ_SUSPEND] | req[REQ_RESUME])); // R6

    AST_SUSPEND_ONLY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_erase && !busy_prog && !suspended) |=> !req[REQ_SUSPEND]); // R7

    AST_SUSP_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && !busy_prog) |=> !(req[REQ_RD_ID] | req[REQ_CLR] | req[REQ_PROGRAM]
                        | req[REQ_CHIP] | req[REQ_SECTOR] | req[REQ_SUSPEND] | req[REQ_SLEEP])); // R8

    AST_RESUME_NEEDS_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspended || busy_prog) |=> !req[REQ_RESUME]); // R8

    AST_STATUS_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (req[REQ_RD_STATUS] | req[REQ_PROGRAM] | req[REQ_CHIP] | req[REQ_SECTOR])
        |-> (read_sel == 2'd2)); // R9

    AST_ARRAY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        req[REQ_RD_ARRAY] |-> (read_sel == 2'd0)); // R9

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .busy_prog  (busy_prog),
    .busy_erase (busy_erase),
    .suspended  (suspended),
    .req        (req),
    .read_sel   (read_sel)
);

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;

    localparam int C_RA = 1, C_ID = 2, C_RS = 3, C_CS = 4, C_PROG = 5, C_CHIP = 6,
                   C_SECT = 7, C_SUSP = 8, C_RES = 9, C_SLEEP = 10, C_ABORT = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy_prog = 1'b0;
    logic        busy_erase = 1'b0;
    logic        suspended = 1'b0;
    logic [10:0] req;
    logic [3:0]  req_sector;
    logic [1:0]  read_sel;

    always #2.5 clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .busy_prog  (busy_prog),
        .busy_erase (busy_erase),
        .suspended  (suspended),
        .req        (req),
        .req_sector (req_sector),
        .read_sel   (read_sel)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int         mst = 0;
    logic [1:0] esel = 2'd0;
    logic [3:0] esect = 4'd0;

    task automatic check(input string rq, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic int byte2cmd(input logic [7:0] b);
        case (b)
            8'hF0: return C_RA;
            8'h90: return C_ID;
            8'h70: return C_RS;
            8'h50: return C_CS;
            8'hA0: return C_PROG;
            8'hB0: return C_SUSP;
            8'hD0: return C_RES;
            8'hC0: return C_SLEEP;
            8'hE0: return C_ABORT;
            default: return 0;
        endcase
    endfunction

    // context: 0 idle, 1 program, 2 erase, 3 suspended (R6 precedence)
    function automatic bit allowed(input int c);
        int ctx;
        if (busy_prog)       ctx = 1;
        else if (suspended)  ctx = 3;
        else if (busy_erase) ctx = 2;
        else                 ctx = 0;
        case (ctx)
            0: return c inside {C_RA, C_ID, C_RS, C_CS, C_PROG, C_CHIP, C_SECT, C_SLEEP};
            1: return c inside {C_RS, C_SLEEP, C_ABORT};
            2: return c inside {C_RS, C_SUSP, C_SLEEP, C_ABORT};
            default: return c inside {C_RA, C_RS, C_ABORT, C_RES};
        endcase
    endfunction

    task automatic model_write(input logic [19:0] a, input logic [15:0] d, output int c);
        bit isa = (a[14:0] == 15'h5555);
        bit isb = (a[14:0] == 15'h2AAA);
        logic [7:0] b = d[7:0];
        c = 0;
        case (mst)
            0: mst = (isa && b == 8'hAA) ? 1 : 0;
            1: mst = (isb && b == 8'h55) ? 2 : 0;
            2: begin
                mst = 0;
                if (isa) begin
                    if (b == 8'h80) mst = 3;
                    else            c = byte2cmd(b);
                end
            end
            3: mst = (isa && b == 8'hAA) ? 4 : 0;
            4: mst = (isb && b == 8'h55) ? 5 : 0;
            default: begin
                mst = 0;
                if (b == 8'h30)             c = C_SECT;
                else if (isa && b == 8'h10) c = C_CHIP;
            end
        endcase
        if (c != 0 && !allowed(c)) c = 0;
        if (c == C_RA) esel = 2'd0;
        else if (c == C_ID) esel = 2'd1;
        else if (c inside {C_RS, C_PROG, C_CHIP, C_SECT, C_SUSP, C_SLEEP, C_ABORT}) esel = 2'd2;
        if (c == C_SECT) esect = a[19:16];
    endtask

    task automatic wr(input logic [19:0] a, input logic [15:0] d, input string rq);
        int c;
        logic [10:0] er;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        model_write(a, d, c);
        er = (c == 0) ? 11'd0 : (11'd1 << (c - 1));
        @(negedge clk);
        wr_en = 1'b0;
        check(rq, "req", int'(req), int'(er));
        check(rq, "read_sel", int'(read_sel), int'(esel));
        check(rq, "req_sector", int'(req_sector), int'(esect));
        @(negedge clk);
        check("R10", "req idle", int'(req), 0);
    endtask

    task automatic cmd3(input logic [7:0] code, input string rq);
        wr(20'h05555, 16'h00AA, rq);
        wr(20'h02AAA, 16'h0055, rq);
        wr(20'h05555, {8'h00, code}, rq);
    endtask

    task automatic erase6(input logic [19:0] last_a, input logic [7:0] last_b, input string rq);
        cmd3(8'h80, rq);
        wr(20'h05555, 16'h00AA, rq);
        wr(20'h02AAA, 16'h0055, rq);
        wr(last_a, {8'h00, last_b}, rq);
    endtask

    task automatic set_ctx(input bit p, input bit e, input bit s);
        @(negedge clk);
        busy_prog = p; busy_erase = e; suspended = s;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        wrap_up();
    end

    initial begin
        logic [19:0] wa [6];
        logic [15:0] wd [6];
        int n;
        void'($urandom(32'd20240607));

        repeat (3) @(negedge clk);
        check("R1", "req in reset", int'(req), 0);
        check("R1", "read_sel in reset", int'(read_sel), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "read_sel after reset", int'(read_sel), 0);

        // R2: read ID with upper address and data bits set
        wr(20'hF5555, 16'h7EAA, "R2");
        wr(20'h3AAAA, 16'hC355, "R2");
        wr(20'h85555, 16'hFF90, "R2");
        cmd3(8'h50, "R9 clear keeps ID select");
        cmd3(8'h70, "R2");
        // R3 sector and chip erase
        erase6(20'hB1234, 8'h30, "R3");
        erase6(20'h05555, 8'h10, "R3");
        erase6(20'h01234, 8'h10, "R3 chip needs 5555");
        // R4 broken prefix
        wr(20'h05555, 16'h00AA, "R4");
        wr(20'h02AAB, 16'h0055, "R4");
        wr(20'h05555, 16'h00F0, "R4");
        cmd3(8'h33, "R4 unknown code");
        // R5 idle ignores suspend, resume, abort
        cmd3(8'hB0, "R5"); cmd3(8'hD0, "R5"); cmd3(8'hE0, "R5");
        cmd3(8'hF0, "R5");
        // R6 program running
        set_ctx(1'b1, 1'b1, 1'b1);
        cmd3(8'hF0, "R6"); cmd3(8'h70, "R6"); cmd3(8'hE0, "R6");
        // R7 erase running
        set_ctx(1'b0, 1'b1, 1'b0);
        cmd3(8'hF0, "R7"); cmd3(8'hB0, "R7"); cmd3(8'hC0, "R7");
        // R8 suspended
        set_ctx(1'b0, 1'b1, 1'b1);
        cmd3(8'hC0, "R8"); cmd3(8'hF0, "R8"); cmd3(8'h90, "R8"); cmd3(8'hD0, "R8");
        set_ctx(1'b0, 1'b0, 1'b0);

        for (int it = 0; it < 400; it++) begin
            int kind = $urandom_range(0, 12);
            int r = $urandom_range(0, 4);
            logic [7:0] codes [9] = '{8'hF0, 8'h90, 8'h70, 8'h50, 8'hA0, 8'hB0, 8'hD0, 8'hC0, 8'hE0};
            case (r)
                0, 4: set_ctx(1'b0, 1'b0, 1'b0);
                1: set_ctx(1'b1, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
                2: set_ctx(1'b0, 1'b1, 1'b0);
                default: set_ctx(1'b0, $urandom_range(0, 1) == 1, 1'b1);
            endcase
            wa[0] = 20'h05555; wd[0] = 16'h00AA;
            wa[1] = 20'h02AAA; wd[1] = 16'h0055;
            wa[2] = 20'h05555; wd[2] = 16'h0080;
            wa[3] = 20'h05555; wd[3] = 16'h00AA;
            wa[4] = 20'h02AAA; wd[4] = 16'h0055;
            n = 3;
            if (kind < 9) begin
                wd[2] = {8'h00, codes[kind]};
            end else if (kind == 9) begin
                n = 6; wa[5] = 20'h05555; wd[5] = 16'h0010;
            end else if (kind == 10) begin
                n = 6; wa[5] = 20'($urandom); wd[5] = 16'h0030;
            end else if (kind == 11) begin
                wd[2] = 16'($urandom);
            end else begin
                n = 1; wa[0] = 20'($urandom); wd[0] = 16'($urandom);
            end
            for (int k = 0; k < n; k++) begin
                wa[k][19:15] = 5'($urandom);
                wd[k][15:8]  = 8'($urandom);
            end
            if ($urandom_range(0, 5) == 0) begin
                int k = $urandom_range(0, n - 1);
                if ($urandom_range(0, 1) == 1) wd[k][$urandom_range(0, 7)] ^= 1'b1;
                else                           wa[k][$urandom_range(0, 14)] ^= 1'b1;
            end
            for (int k = 0; k < n; k++) wr(wa[k], wd[k], "RND");
        end

        wrap_up();
    end

endmodule